// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

The block moves data from a source region to a destination region under the control of a transfer descriptor. The descriptor holds two start addresses and a signed step for each side. It also holds an access width for each side, a per-service byte count, a running and a reload iteration count, a signed wrap adjustment for each side, and two control flags: start-now and stop-at-end. A transfer is two nested loops. The inner loop copies the programmed byte count without interruption. The outer loop counts these inner loops down. When the count runs out, the engine adds the wrap adjustments to both addresses, reloads the count and raises a done flag.

An inner loop is started in one of two ways. The start-now flag starts one inner loop as soon as the descriptor lands. A hardware request line also starts inner loops while its enable is set. Reads go out over a request/acknowledge port and writes over a second one. A small byte holding buffer lets the read width differ from the write width. An error response stops the current inner loop, and an optional halt mode then keeps the engine idle until software reloads it.

Top module: `tcd_dma_engine`

## Requirements
- R1: After reset the engine is idle: `sts_active`, `rd_req`, `wr_req`, `sts_done`, `sts_error`, `sts_halted` and `hreq_enabled` are all 0.
- R2: A descriptor loaded with `desc_start`=1 runs exactly one inner loop, which moves `desc_nbytes` bytes, and then returns to idle. The start flag clears itself, so no second inner loop follows, and `cur_iter` drops by exactly one.
- R3: Each completed read adds the sign-extended `desc_src_step` to the source address. Each completed write adds the sign-extended `desc_dst_step` to the destination address. Negative steps walk the address downward.
- R4: The width codes are 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, and 2'b11 is treated as 4 bytes. `rd_size` and `wr_size` carry the code of their side. Data is right-aligned on both buses. Bytes from successive reads fill the holding buffer from byte lane 0 upward, and writes drain it from lane 0. A 1-byte source feeding a 4-byte destination therefore makes four reads and one write.
- R5: While `hreq_enabled` is 1, a high `hw_req` seen in an idle cycle starts an inner loop. A request held high keeps starting inner loops until the outer loop finishes.
- R6: `cur_iter` drops by one per completed inner loop. The inner loop that completes while `cur_iter` is 1 (or 0) reloads `cur_iter` from `desc_iter_begin`. That same loop adds the signed `desc_src_wrap` and `desc_dst_wrap` to the addresses, after the last step has been applied.
- R7: `sts_done` becomes 1 when the outer loop finishes. It stays at 1 until the next accepted descriptor load, which clears it.
- R8: With `desc_stop_at_end`=1, `hreq_enabled` clears when the outer loop finishes, so a request held high stops there. With the flag at 0, a held request carries on into the next outer loop. When both happen in one cycle, the automatic clear overrides a software write to the enable.
- R9: `sts_active` is 1 from the cycle after an inner loop is accepted until that inner loop completes or aborts, and is 0 otherwise.
- R10: An error response on either port sets `sts_error` and aborts the inner loop, leaving `cur_iter` unchanged. With `halt_on_err`=0 the engine keeps serving requests. With `halt_on_err`=1, `sts_halted` is set and no inner loop starts until a descriptor load, which clears both `sts_error` and `sts_halted`.
- R11: A descriptor load arriving in the same cycle as a pending request takes precedence, so the first inner loop uses the new descriptor. A descriptor load while `sts_active` is 1 is ignored.
- R12: At most one access is outstanding: `rd_req` and `wr_req` are never both 1. A request stays high, with a stable address, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Load the descriptor fields below (accepted only when idle) |
| desc_src_addr | input | ADDR_W | Source start address |
| desc_dst_addr | input | ADDR_W | Destination start address |
| desc_src_step | input | OFF_W | Signed source step per read |
| desc_dst_step | input | OFF_W | Signed destination step per write |
| desc_src_size | input | 2 | Source width code |
| desc_dst_size | input | 2 | Destination width code |
| desc_nbytes | input | NB_W | Bytes per inner loop |
| desc_iter | input | ITER_W | Initial iteration count |
| desc_iter_begin | input | ITER_W | Reload iteration count (equal to desc_iter) |
| desc_src_wrap | input | ADDR_W | Signed source adjustment at outer-loop end |
| desc_dst_wrap | input | ADDR_W | Signed destination adjustment at outer-loop end |
| desc_start | input | 1 | Start one inner loop after load |
| desc_stop_at_end | input | 1 | Clear request enable at outer-loop end |
| hreq_en_wr | input | 1 | Write strobe for the request enable |
| hreq_en_val | input | 1 | Value written to the request enable |
| hw_req | input | 1 | Hardware service request |
| halt_on_err | input | 1 | Halt after any error response |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_size | output | 2 | Read width code |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | 32 | Read data, right-aligned |
| rd_err | input | 1 | Read error, valid with rd_ack |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Write data, right-aligned |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, valid with wr_ack |
| sts_active | output | 1 | Inner loop in progress |
| sts_done | output | 1 | Outer loop finished |
| sts_error | output | 1 | An error response was seen |
| sts_halted | output | 1 | Halted after an error |
| hreq_enabled | output | 1 | Current request enable |
| cur_iter | output | ITER_W | Running iteration count |
| cur_src_addr | output | ADDR_W | Current source address |
| cur_dst_addr | output | ADDR_W | Current destination address |

## Verification
A descriptor load and the start of a hardware-requested inner loop can both fall in the same idle cycle. The bench enables requests, then raises `hw_req` and `desc_load` on the same clock edge with a source address that differs from the previous descriptor's. It judges the outcome from the first read address the memory model logs, which must be the new one. It also pulses a second load while the engine is active and requires that the source address continues the original sequence. A second such pairing arises when the last inner loop finishes with the stop-at-end flag set while a request is still held high. The bench confirms that no further reads appear and that the request enable has dropped.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [1:0] src_sz;
        logic [1:0] dst_sz;
        logic       stop_at_end;
    } xfer_attr_t;

    // width code to byte count; the spare code behaves as a full word
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   size_bytes = 3'd1;
            2'b01:   size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // mask covering the lowest nb byte lanes
    function automatic logic [DW-1:0] lane_mask(input logic [2:0] nb);
        if (32'(nb) >= LANES)
            lane_mask = '1;
        else
            lane_mask = (DW'(1) << (32'(nb) * 8)) - DW'(1);
    endfunction

endpackage

// File: rtl/tcd_pack_buf.sv
module tcd_pack_buf
    import tcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [2:0]    push_bytes,
    input  logic          pop,
    input  logic [2:0]    pop_bytes,
    output logic [2:0]    level,
    output logic [DW-1:0] head
);

    logic [DW-1:0] data_q;
    logic [2:0]    level_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data_q  <= '0;
            level_q <= '0;
        end else if (push) begin
            data_q  <= data_q | ((push_data & lane_mask(push_bytes)) << (32'(level_q) * 8));
            level_q <= level_q + push_bytes;
        end else if (pop) begin
            data_q  <= data_q >> (32'(pop_bytes) * 8);
            level_q <= level_q - pop_bytes;
        end
    end

    assign level = level_q;
    assign head  = data_q;

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(level_q) <= LANES);

    // R4
    pop_cover_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> level_q >= pop_bytes);

endmodule

// File: rtl/tcd_iter_cnt.sv
module tcd_iter_cnt #(
    parameter int ITER_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ITER_W-1:0] load_cur,
    input  logic [ITER_W-1:0] load_begin,
    input  logic              step,
    output logic [ITER_W-1:0] cur,
    output logic              last
);

    logic [ITER_W-1:0] cur_q;
    logic [ITER_W-1:0] begin_q;

    assign last = (cur_q <= ITER_W'(1));
    assign cur  = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            begin_q <= '0;
        end else if (load) begin
            cur_q   <= load_cur;
            begin_q <= load_begin;
        end else if (step) begin
            cur_q <= last ? begin_q : cur_q - ITER_W'(1);
        end
    end

    // R6
    iter_dec_chk: assert property (@(posedge clk) disable iff (rst)
        step && !load && (cur_q > ITER_W'(1)) |=> cur_q == $past(cur_q) - ITER_W'(1));

    // R6
    iter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step && !load |=> $stable(cur_q));

endmodule

// File: rtl/tcd_seq.sv
module tcd_seq
    import tcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int NB_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  logic [OFF_W-1:0]  d_soff,
    input  logic [OFF_W-1:0]  d_doff,
    input  xfer_attr_t        d_attr,
    input  logic [NB_W-1:0]   d_nbytes,
    input  logic [ADDR_W-1:0] d_slast,
    input  logic [ADDR_W-1:0] d_dlast,
    input  logic              d_start,
    input  logic              hreq_en_wr,
    input  logic              hreq_en_val,
    input  logic              hw_req,
    input  logic              halt_on_err,
    input  logic              iter_last,
    output logic              iter_load,
    output logic              iter_step,
    input  logic [2:0]        buf_level,
    input  logic [DW-1:0]     buf_head,
    output logic              buf_clr,
    output logic              buf_push,
    output logic              buf_pop,
    output logic [2:0]        push_bytes,
    output logic [2:0]        pop_bytes,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_ack,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [DW-1:0]     wr_data,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              sts_active,
    output logic              sts_done,
    output logic              sts_error,
    output logic              sts_halted,
    output logic              hreq_enabled,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst
);

    localparam int EXT_W = ADDR_W - OFF_W;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] src_q, dst_q, slast_q, dlast_q;
    logic [OFF_W-1:0]  soff_q, doff_q;
    xfer_attr_t        attr_q;
    logic [NB_W-1:0]   nbytes_q, left_q;
    logic              start_q, req_en_q, done_q, err_q, halt_q;

    logic load_ok, go, rd_ok, rd_bad, wr_ok, wr_bad, minor_end;
    logic [ADDR_W-1:0] soff_ext, doff_ext;

    assign soff_ext  = {{EXT_W{soff_q[OFF_W-1]}}, soff_q};
    assign doff_ext  = {{EXT_W{doff_q[OFF_W-1]}}, doff_q};

    assign load_ok   = desc_load && (state_q == ST_IDLE);
    assign go        = (state_q == ST_IDLE) && !load_ok && !halt_q
                       && (start_q || (hw_req && req_en_q));
    assign rd_ok     = (state_q == ST_READ)  && rd_ack && !rd_err;
    assign rd_bad    = (state_q == ST_READ)  && rd_ack &&  rd_err;
    assign wr_ok     = (state_q == ST_WRITE) && wr_ack && !wr_err;
    assign wr_bad    = (state_q == ST_WRITE) && wr_ack &&  wr_err;
    assign minor_end = (state_q == ST_PICK)  && (left_q == '0);

    assign push_bytes = size_bytes(attr_q.src_sz);
    assign pop_bytes  = size_bytes(attr_q.dst_sz);
    assign buf_clr    = go;
    assign buf_push   = rd_ok;
    assign buf_pop    = wr_ok;
    assign iter_load  = load_ok;
    assign iter_step  = minor_end;

    assign rd_req  = (state_q == ST_READ);
    assign rd_addr = src_q;
    assign rd_size = attr_q.src_sz;
    assign wr_req  = (state_q == ST_WRITE);
    assign wr_addr = dst_q;
    assign wr_size = attr_q.dst_sz;
    assign wr_data = buf_head & lane_mask(pop_bytes);

    assign sts_active   = (state_q != ST_IDLE);
    assign sts_done     = done_q;
    assign sts_error    = err_q;
    assign sts_halted   = halt_q;
    assign hreq_enabled = req_en_q;
    assign cur_src      = src_q;
    assign cur_dst      = dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            src_q    <= '0;
            dst_q    <= '0;
            slast_q  <= '0;
            dlast_q  <= '0;
            soff_q   <= '0;
            doff_q   <= '0;
            attr_q   <= '0;
            nbytes_q <= '0;
            left_q   <= '0;
            start_q  <= 1'b0;
            req_en_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            halt_q   <= 1'b0;
        end else begin
            if (hreq_en_wr)
                req_en_q <= hreq_en_val;
            case (state_q)
                ST_IDLE: begin
                    if (load_ok) begin
                        src_q    <= d_src;
                        dst_q    <= d_dst;
                        soff_q   <= d_soff;
                        doff_q   <= d_doff;
                        attr_q   <= d_attr;
                        nbytes_q <= d_nbytes;
                        slast_q  <= d_slast;
                        dlast_q  <= d_dlast;
                        start_q  <= d_start;
                        done_q   <= 1'b0;
                        err_q    <= 1'b0;
                        halt_q   <= 1'b0;
                    end else if (go) begin
                        start_q <= 1'b0;
                        left_q  <= nbytes_q;
                        state_q <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (left_q == '0) begin
                        state_q <= ST_IDLE;
                        if (iter_last) begin
                            src_q  <= src_q + slast_q;
                            dst_q  <= dst_q + dlast_q;
                            done_q <= 1'b1;
                            if (attr_q.stop_at_end)
                                req_en_q <= 1'b0;
                        end
                    end else if (buf_level >= pop_bytes) begin
                        state_q <= ST_WRITE;
                    end else begin
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_bad) begin
                        err_q   <= 1'b1;
                        halt_q  <= halt_q | halt_on_err;
                        state_q <= ST_IDLE;
                    end else if (rd_ok) begin
                        src_q   <= src_q + soff_ext;
                        state_q <= ST_PICK;
                    end
                end
                ST_WRITE: begin
                    if (wr_bad) begin
                        err_q   <= 1'b1;
                        halt_q  <= halt_q | halt_on_err;
                        state_q <= ST_IDLE;
                    end else if (wr_ok) begin
                        dst_q   <= dst_q + doff_ext;
                        left_q  <= (left_q > NB_W'(pop_bytes)) ? left_q - NB_W'(pop_bytes) : '0;
                        state_q <= ST_PICK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R12
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R10
    halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        halt_q && !desc_load |=> (state_q == ST_IDLE));

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(state_q) == ST_PICK);

    // R11
    busy_load_chk: assert property (@(posedge clk) disable iff (rst)
        sts_active && !rd_ok && !wr_ok && !minor_end |=> $stable(src_q) && $stable(dst_q));

endmodule

// File: rtl/tcd_dma_engine.sv
module tcd_dma_engine
    import tcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int NB_W   = 16,
    parameter int ITER_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_src_addr,
    input  logic [ADDR_W-1:0] desc_dst_addr,
    input  logic [OFF_W-1:0]  desc_src_step,
    input  logic [OFF_W-1:0]  desc_dst_step,
    input  logic [1:0]        desc_src_size,
    input  logic [1:0]        desc_dst_size,
    input  logic [NB_W-1:0]   desc_nbytes,
    input  logic [ITER_W-1:0] desc_iter,
    input  logic [ITER_W-1:0] desc_iter_begin,
    input  logic [ADDR_W-1:0] desc_src_wrap,
    input  logic [ADDR_W-1:0] desc_dst_wrap,
    input  logic              desc_start,
    input  logic              desc_stop_at_end,
    input  logic              hreq_en_wr,
    input  logic              hreq_en_val,
    input  logic              hw_req,
    input  logic              halt_on_err,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              sts_active,
    output logic              sts_done,
    output logic              sts_error,
    output logic              sts_halted,
    output logic              hreq_enabled,
    output logic [ITER_W-1:0] cur_iter,
    output logic [ADDR_W-1:0] cur_src_addr,
    output logic [ADDR_W-1:0] cur_dst_addr
);

    xfer_attr_t    attr_in;
    logic          it_load, it_step, it_last;
    logic          b_clr, b_push, b_pop;
    logic [2:0]    b_push_n, b_pop_n, b_level;
    logic [DW-1:0] b_head;

    assign attr_in = '{src_sz: desc_src_size, dst_sz: desc_dst_size,
                       stop_at_end: desc_stop_at_end};

    tcd_seq #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB_W(NB_W)
    ) seq_i (
        .clk(clk), .rst(rst),
        .desc_load(desc_load),
        .d_src(desc_src_addr), .d_dst(desc_dst_addr),
        .d_soff(desc_src_step), .d_doff(desc_dst_step),
        .d_attr(attr_in), .d_nbytes(desc_nbytes),
        .d_slast(desc_src_wrap), .d_dlast(desc_dst_wrap),
        .d_start(desc_start),
        .hreq_en_wr(hreq_en_wr), .hreq_en_val(hreq_en_val),
        .hw_req(hw_req), .halt_on_err(halt_on_err),
        .iter_last(it_last), .iter_load(it_load), .iter_step(it_step),
        .buf_level(b_level), .buf_head(b_head),
        .buf_clr(b_clr), .buf_push(b_push), .buf_pop(b_pop),
        .push_bytes(b_push_n), .pop_bytes(b_pop_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ack(rd_ack), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
        .sts_active(sts_active), .sts_done(sts_done),
        .sts_error(sts_error), .sts_halted(sts_halted),
        .hreq_enabled(hreq_enabled),
        .cur_src(cur_src_addr), .cur_dst(cur_dst_addr)
    );

    tcd_iter_cnt #(
        .ITER_W(ITER_W)
    ) iter_i (
        .clk(clk), .rst(rst),
        .load(it_load), .load_cur(desc_iter), .load_begin(desc_iter_begin),
        .step(it_step), .cur(cur_iter), .last(it_last)
    );

    tcd_pack_buf buf_i (
        .clk(clk), .rst(rst), .clr(b_clr),
        .push(b_push), .push_data(rd_data), .push_bytes(b_push_n),
        .pop(b_pop), .pop_bytes(b_pop_n),
        .level(b_level), .head(b_head)
    );

endmodule

// File: tb/tcd_dma_engine_tb.sv
module tcd_dma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_load = 1'b0;
    logic [31:0] desc_src_addr = '0, desc_dst_addr = '0;
    logic [15:0] desc_src_step = '0, desc_dst_step = '0;
    logic [1:0]  desc_src_size = '0, desc_dst_size = '0;
    logic [15:0] desc_nbytes = '0;
    logic [14:0] desc_iter = '0, desc_iter_begin = '0;
    logic [31:0] desc_src_wrap = '0, desc_dst_wrap = '0;
    logic        desc_start = 1'b0, desc_stop_at_end = 1'b0;
    logic        hreq_en_wr = 1'b0, hreq_en_val = 1'b0, hw_req = 1'b0, halt_on_err = 1'b0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        sts_active, sts_done, sts_error, sts_halted, hreq_enabled;
    logic [14:0] cur_iter;
    logic [31:0] cur_src_addr, cur_dst_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rn = 0;
    int wn = 0;
    int both_cnt = 0;
    logic        bad_en = 1'b0;
    logic [31:0] bad_addr = '0;
    logic [7:0]  mem [256];
    logic [31:0] rlog [1024];

    always #4 clk = ~clk;

    tcd_dma_engine dut_i (
        .clk(clk), .rst(rst), .desc_load(desc_load),
        .desc_src_addr(desc_src_addr), .desc_dst_addr(desc_dst_addr),
        .desc_src_step(desc_src_step), .desc_dst_step(desc_dst_step),
        .desc_src_size(desc_src_size), .desc_dst_size(desc_dst_size),
        .desc_nbytes(desc_nbytes), .desc_iter(desc_iter),
        .desc_iter_begin(desc_iter_begin),
        .desc_src_wrap(desc_src_wrap), .desc_dst_wrap(desc_dst_wrap),
        .desc_start(desc_start), .desc_stop_at_end(desc_stop_at_end),
        .hreq_en_wr(hreq_en_wr), .hreq_en_val(hreq_en_val),
        .hw_req(hw_req), .halt_on_err(halt_on_err),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
        .sts_active(sts_active), .sts_done(sts_done), .sts_error(sts_error),
        .sts_halted(sts_halted), .hreq_enabled(hreq_enabled),
        .cur_iter(cur_iter), .cur_src_addr(cur_src_addr), .cur_dst_addr(cur_dst_addr)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    end

    // memory model: one-cycle acknowledge, byte-addressed, right-aligned data
    always @(posedge clk) begin
        rd_ack <= 1'b0;
        rd_err <= 1'b0;
        wr_ack <= 1'b0;
        wr_err <= 1'b0;
        if (rd_req && !rd_ack) begin
            logic [31:0] w;
            w = {mem[rd_addr[7:0] + 8'd3], mem[rd_addr[7:0] + 8'd2],
                 mem[rd_addr[7:0] + 8'd1], mem[rd_addr[7:0]]};
            case (rd_size)
                2'b00:   rd_data <= w & 32'h0000_00FF;
                2'b01:   rd_data <= w & 32'h0000_FFFF;
                default: rd_data <= w;
            endcase
            rd_ack <= 1'b1;
            rd_err <= bad_en && (rd_addr == bad_addr);
            rlog[rn % 1024] <= rd_addr;
            rn <= rn + 1;
        end
        if (wr_req && !wr_ack) begin
            int nb;
            nb = (wr_size == 2'b00) ? 1 : (wr_size == 2'b01) ? 2 : 4;
            for (int b = 0; b < 4; b++)
                if (b < nb) mem[wr_addr[7:0] + 8'(b)] <= wr_data[8*b +: 8];
            wr_ack <= 1'b1;
            wn <= wn + 1;
        end
    end

    always @(negedge clk) if (rd_req && wr_req) both_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] so, input logic [15:0] dso,
                            input logic [1:0] ss, input logic [1:0] ds,
                            input logic [15:0] nb, input logic [14:0] it,
                            input logic [31:0] sw, input logic [31:0] dw,
                            input logic st, input logic se);
        desc_src_addr = s;   desc_dst_addr = d;
        desc_src_step = so;  desc_dst_step = dso;
        desc_src_size = ss;  desc_dst_size = ds;
        desc_nbytes = nb;    desc_iter = it; desc_iter_begin = it;
        desc_src_wrap = sw;  desc_dst_wrap = dw;
        desc_start = st;     desc_stop_at_end = se;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        desc_load = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
    endtask

    task automatic set_req_en(input logic v);
        @(negedge clk);
        hreq_en_wr = 1'b1;
        hreq_en_val = v;
        @(negedge clk);
        hreq_en_wr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2000 && sts_active; k++) @(negedge clk);
    endtask

    function automatic int copy_miss(input int s, input int d, input int n);
        int m = 0;
        for (int k = 0; k < n; k++)
            if (mem[8'(d + k)] !== mem[8'(s + k)]) m++;
        return m;
    endfunction

    task automatic t_reset();
        chk("R1 active", 32'(sts_active), 0);
        chk("R1 rd_req", 32'(rd_req), 0);
        chk("R1 wr_req", 32'(wr_req), 0);
        chk("R1 done/err/halt", {29'd0, sts_done, sts_error, sts_halted}, 0);
        chk("R1 req enable", 32'(hreq_enabled), 0);
    endtask

    task automatic t_start_once();
        set_desc(32'h10, 32'h80, 16'd4, 16'd4, 2'b10, 2'b10, 16'd8, 15'd3, 0, 0, 1'b1, 1'b0);
        pulse_load();
        @(negedge clk);
        chk("R9 active during loop", 32'(sts_active), 1);
        wait_idle();
        chk("R9 active after loop", 32'(sts_active), 0);
        chk("R2 data copied", 32'(copy_miss(32'h10, 32'h80, 8)), 0);
        chk("R2 iter dropped by one", 32'(cur_iter), 2);
        chk("R3 src advanced", cur_src_addr, 32'h18);
        chk("R3 dst advanced", cur_dst_addr, 32'h88);
        chk("R7 not done mid-count", 32'(sts_done), 0);
        repeat (12) @(negedge clk);
        chk("R2 start self-cleared", 32'(cur_iter), 2);
    endtask

    task automatic t_sizes();
        int r0, w0;
        set_desc(32'h20, 32'h90, 16'd1, 16'd4, 2'b00, 2'b10, 16'd4, 15'd1, 0, 0, 1'b1, 1'b0);
        r0 = rn; w0 = wn;
        pulse_load();
        wait_idle();
        chk("R4 four byte reads", 32'(rn - r0), 4);
        chk("R4 one word write", 32'(wn - w0), 1);
        chk("R4 byte packing", 32'(copy_miss(32'h20, 32'h90, 4)), 0);
        chk("R3 src byte step", cur_src_addr, 32'h24);
        // word source, byte destination walking down
        set_desc(32'h30, 32'hA3, 16'd4, 16'hFFFF, 2'b10, 2'b00, 16'd4, 15'd1, 0, 0, 1'b1, 1'b0);
        r0 = rn; w0 = wn;
        pulse_load();
        wait_idle();
        chk("R4 one word read", 32'(rn - r0), 1);
        chk("R4 four byte writes", 32'(wn - w0), 4);
        chk("R3 negative step data", {mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]},
            {mem[8'h33], mem[8'h32], mem[8'h31], mem[8'h30]});
        chk("R3 negative step address", cur_dst_addr, 32'h9F);
    endtask

    task automatic t_major_stop();
        int w0;
        set_desc(32'h40, 32'hC0, 16'd2, 16'd2, 2'b01, 2'b01, 16'd4, 15'd3,
                 32'hFFFF_FFF4, 32'hFFFF_FFF4, 1'b0, 1'b1);
        pulse_load();
        set_req_en(1'b1);
        w0 = wn;
        @(negedge clk);
        hw_req = 1'b1;
        for (int k = 0; k < 3000 && !sts_done; k++) @(negedge clk);
        repeat (25) @(negedge clk);
        chk("R5 held request ran all loops", 32'(wn - w0), 6);
        chk("R5 data copied", 32'(copy_miss(32'h40, 32'hC0, 12)), 0);
        chk("R7 done set", 32'(sts_done), 1);
        chk("R6 iter reloaded", 32'(cur_iter), 3);
        chk("R6 src wrapped", cur_src_addr, 32'h40);
        chk("R6 dst wrapped", cur_dst_addr, 32'hC0);
        chk("R8 enable cleared", 32'(hreq_enabled), 0);
        chk("R8 held request stopped", 32'(sts_active), 0);
        hw_req = 1'b0;
    endtask

    task automatic t_major_continue();
        int w0;
        set_desc(32'h00, 32'hE0, 16'd4, 16'd4, 2'b10, 2'b10, 16'd4, 15'd2,
                 32'hFFFF_FFF8, 32'hFFFF_FFF8, 1'b0, 1'b0);
        pulse_load();
        chk("R7 load clears done", 32'(sts_done), 0);
        set_req_en(1'b1);
        @(negedge clk);
        hw_req = 1'b1;
        for (int k = 0; k < 3000 && !sts_done; k++) @(negedge clk);
        w0 = wn;
        repeat (40) @(negedge clk);
        chk("R8 continues without stop flag", 32'(wn > w0), 1);
        chk("R8 enable kept", 32'(hreq_enabled), 1);
        hw_req = 1'b0;
        wait_idle();
        set_req_en(1'b0);
    endtask

    task automatic t_errors();
        int r0;
        halt_on_err = 1'b0;
        bad_en = 1'b1;
        bad_addr = 32'h54;
        set_desc(32'h50, 32'h88, 16'd4, 16'd4, 2'b10, 2'b10, 16'd8, 15'd4, 0, 0, 1'b1, 1'b0);
        pulse_load();
        wait_idle();
        chk("R10 error flagged", 32'(sts_error), 1);
        chk("R10 iter unchanged on abort", 32'(cur_iter), 4);
        chk("R10 not halted", 32'(sts_halted), 0);
        bad_en = 1'b0;
        set_req_en(1'b1);
        @(negedge clk);
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
        wait_idle();
        chk("R10 still serves requests", 32'(cur_iter), 3);
        // halting variant
        halt_on_err = 1'b1;
        bad_en = 1'b1;
        pulse_load();
        wait_idle();
        chk("R10 halted", 32'(sts_halted), 1);
        r0 = rn;
        @(negedge clk);
        hw_req = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 no reads while halted", 32'(rn - r0), 0);
        chk("R10 iter frozen while halted", 32'(cur_iter), 4);
        hw_req = 1'b0;
        bad_en = 1'b0;
        set_desc(32'h50, 32'h88, 16'd4, 16'd4, 2'b10, 2'b10, 16'd8, 15'd4, 0, 0, 1'b0, 1'b0);
        pulse_load();
        chk("R10 load clears halt and error", {30'd0, sts_halted, sts_error}, 0);
        halt_on_err = 1'b0;
    endtask

    task automatic t_collide();
        int r0;
        // request enable is still set from the previous scenario
        set_desc(32'h60, 32'hB0, 16'd4, 16'd4, 2'b10, 2'b10, 16'd8, 15'd1, 0, 0, 1'b0, 1'b1);
        @(negedge clk);
        r0 = rn;
        desc_load = 1'b1;
        hw_req = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
        @(negedge clk);
        // engine is busy here: this load must be ignored
        set_desc(32'h70, 32'hB8, 16'd4, 16'd4, 2'b10, 2'b10, 16'd8, 15'd1, 0, 0, 1'b1, 1'b0);
        desc_load = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        hw_req = 1'b0;
        chk("R11 first read uses new descriptor", rlog[r0 % 1024], 32'h60);
        chk("R11 busy load ignored", cur_src_addr, 32'h68);
        chk("R11 no extra loop", 32'(rn - r0), 2);
        chk("R11 done from first descriptor", 32'(sts_done), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_once();
        t_sizes();
        t_major_stop();
        t_major_continue();
        t_errors();
        t_collide();
        chk("R12 never both ports", 32'(both_cnt), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule